// File: doc/BRIEF.md
# MDIO Management Frame Master

This block serialises clause-22 management transactions to an Ethernet PHY. A host issues one command, which is a start strobe, a read/write select, a 5-bit PHY address, a 5-bit register address and 16 bits of write data. The block then drives a complete frame on the management clock (MDC) and on the bidirectional data line (MDIO). The line is split into an output value (`mdio_o`), an output enable (`mdio_oe`) and an input sample (`mdio_i`), and the pad that combines them sits outside this block.

Every serial bit is built from four sub-phases: MDC low, high, high and low. Each sub-phase lasts `HOLD_CYCLES` system clocks, so one MDC period is four times that count. The driven value and its enable do not change within a bit.

A frame has these parts, in order:
- a preamble of ones;
- a 14-bit command;
- a turnaround;
- 16 data bits;
- one released idle bit.

On a read, the block releases the line for the turnaround and for the data bits. It samples the PHY's data during the first MDC-high sub-phase of each data bit. When the frame ends, `done` pulses for one clock and the read result is valid on `rd_data` in that same clock.

Top module: `mdio_frame_master`

## Requirements
- R1: After reset and whenever `busy` is low, `mdc` is 0, `mdio_oe` is 0, and `done` is 0 except in its pulse cycle.
- R2: Each frame begins with 32 bits of value 1, driven with `mdio_oe`=1.
- R3: The next 14 driven bits go MSB first: start code 0,1, then the opcode (0,1 for write, 1,0 for read), then the PHY address MSB first, then the register address MSB first.
- R4: After the command, a write drives the turnaround bits 1 then 0 and then the 16 write-data bits MSB first. It then releases the line (`mdio_oe`=0) for one idle bit, giving 65 bits in total.
- R5: After the command, a read keeps `mdio_oe`=0 for one turnaround bit, 16 data bits and one idle bit, giving 64 bits in total.
- R6: Each bit lasts 4×`HOLD_CYCLES` clocks. MDC is low, high, high and low over its four equal sub-phases. `mdio_o` and `mdio_oe` stay constant for the whole bit.
- R7: During each read data bit, `mdio_i` is sampled in the last clock of the first MDC-high sub-phase and shifted into the LSB of the result. After the frame, `rd_data` therefore holds the 16 sampled bits with the first one received in bit 15.
- R8: `cmd_start` is accepted on a rising clock edge while `busy` is low. `busy` is high from the next cycle for exactly N×4×`HOLD_CYCLES` cycles (N = 65 for a write, 64 for a read). In the following cycle `done` is 1 for one clock with `busy` low, and `rd_data` is valid in that cycle.
- R9: A `cmd_start` asserted while `busy` is high is ignored. The running frame continues unchanged, and no new frame starts after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start strobe for one transaction |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address |
| cmd_wdata | input | 16 | Write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 16 | Read result, valid with `done` |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO drive value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO sampled input |

## Verification
The start strobe is applied at a falling edge and is captured at the following rising edge. From the next falling edge onward, the bench counts whole cycles. Bit b, sub-phase p occupies cycle indices b×4H + p×H up to that value plus H−1. The bench checks MDC, the drive value and the enable at every one of those falling edges. `done`, `busy` and `rd_data` are checked at cycle index N×4H, and the end of the pulse is checked one cycle later. To show that the sample point is the first high sub-phase, the bench inverts `mdio_i` from the second high sub-phase onward in every read data bit.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

   // Frame sections, walked in declaration order
   typedef enum logic [2:0] {
      FLD_IDLE,
      FLD_PRE,
      FLD_CMD,
      FLD_TA,
      FLD_DATA,
      FLD_END
   } mdio_field_e;

   localparam logic [1:0] SOF_CODE = 2'b01;
   localparam logic [1:0] OP_WRITE = 2'b01;
   localparam logic [1:0] OP_READ  = 2'b10;

   // Turnaround length depends on direction
   function automatic int ta_bits(input logic is_read);
      return is_read ? 1 : 2;
   endfunction

endpackage

// File: rtl/mdio_phase_timer.sv
module mdio_phase_timer #(
   parameter int HOLD_CYCLES = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sample_stb,
   output logic bit_end,
   output logic mdc
);

   logic [1:0] phase_q;
   logic       phase_last;

   generate
      if (HOLD_CYCLES < 1) begin : g_bad_hold
         $error("HOLD_CYCLES must be at least 1");
      end
      if (HOLD_CYCLES == 1) begin : g_single
         assign phase_last = 1'b1;
      end else begin : g_count
         localparam int HW = $clog2(HOLD_CYCLES);
         logic [HW-1:0] hold_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hold_q <= '0;
            end else if (!run || phase_last) begin
               hold_q <= '0;
            end else begin
               hold_q <= hold_q + 1'b1;
            end
         end

         assign phase_last = (hold_q == HW'(HOLD_CYCLES - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= 2'd0;
      end else if (!run) begin
         phase_q <= 2'd0;
      end else if (phase_last) begin
         phase_q <= phase_q + 2'd1;
      end
   end

   assign mdc        = (phase_q == 2'd1) || (phase_q == 2'd2);
   assign sample_stb = run && phase_last && (phase_q == 2'd1);
   assign bit_end    = run && phase_last && (phase_q == 2'd3);

   // R6
   mdc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && !$past(phase_last)) |-> $stable(mdc));

   // R6
   mdc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_stb) |-> mdc);

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
   import mdio_mgmt_pkg::*;
#(
   parameter int ADDR_W        = 5,
   parameter int DATA_W        = 16,
   parameter int PREAMBLE_BITS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_start,
   input  logic              cmd_read,
   input  logic [ADDR_W-1:0] cmd_phy,
   input  logic [ADDR_W-1:0] cmd_reg,
   input  logic [DATA_W-1:0] cmd_wdata,
   input  logic              bit_end,
   output logic              launch,
   output logic              busy,
   output logic              done,
   output logic              is_read,
   output mdio_field_e       field,
   output logic              drv_val,
   output logic              drv_oe
);

   localparam int CMD_BITS = 4 + 2 * ADDR_W;
   localparam int MAX_LEN_A = (PREAMBLE_BITS > DATA_W) ? PREAMBLE_BITS : DATA_W;
   localparam int MAX_LEN   = (MAX_LEN_A > CMD_BITS) ? MAX_LEN_A : CMD_BITS;
   localparam int IW        = $clog2(MAX_LEN + 1);

   generate
      if (ADDR_W < 1 || DATA_W < 1 || PREAMBLE_BITS < 1) begin : g_bad_cfg
         $error("frame field widths must be positive");
      end
   endgenerate

   mdio_field_e         field_q;
   logic [IW-1:0]       idx_q;
   logic                read_q;
   logic                done_q;
   logic [CMD_BITS-1:0] cmd_sr;
   logic [DATA_W-1:0]   wd_sr;
   int                  fld_len;
   logic                last_bit;

   assign launch = (field_q == FLD_IDLE) && cmd_start;

   always_comb begin
      case (field_q)
         FLD_PRE:  fld_len = PREAMBLE_BITS;
         FLD_CMD:  fld_len = CMD_BITS;
         FLD_TA:   fld_len = ta_bits(read_q);
         FLD_DATA: fld_len = DATA_W;
         default:  fld_len = 1;
      endcase
   end

   assign last_bit = (int'(idx_q) == fld_len - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         field_q <= FLD_IDLE;
         idx_q   <= '0;
         read_q  <= 1'b0;
         done_q  <= 1'b0;
         cmd_sr  <= '0;
         wd_sr   <= '0;
      end else begin
         done_q <= 1'b0;
         if (launch) begin
            field_q <= FLD_PRE;
            idx_q   <= '0;
            read_q  <= cmd_read;
            cmd_sr  <= {SOF_CODE, (cmd_read ? OP_READ : OP_WRITE), cmd_phy, cmd_reg};
            wd_sr   <= cmd_wdata;
         end else if (field_q != FLD_IDLE && bit_end) begin
            if (field_q == FLD_CMD) begin
               cmd_sr <= cmd_sr << 1;
            end
            if (field_q == FLD_DATA && !read_q) begin
               wd_sr <= wd_sr << 1;
            end
            if (last_bit) begin
               idx_q <= '0;
               case (field_q)
                  FLD_PRE:  field_q <= FLD_CMD;
                  FLD_CMD:  field_q <= FLD_TA;
                  FLD_TA:   field_q <= FLD_DATA;
                  FLD_DATA: field_q <= FLD_END;
                  default: begin
                     field_q <= FLD_IDLE;
                     done_q  <= 1'b1;
                  end
               endcase
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end
      end
   end

   always_comb begin
      drv_val = 1'b0;
      drv_oe  = 1'b0;
      case (field_q)
         FLD_PRE: begin
            drv_val = 1'b1;
            drv_oe  = 1'b1;
         end
         FLD_CMD: begin
            drv_val = cmd_sr[CMD_BITS-1];
            drv_oe  = 1'b1;
         end
         FLD_TA: begin
            drv_val = (idx_q == '0);
            drv_oe  = !read_q;
         end
         FLD_DATA: begin
            drv_val = wd_sr[DATA_W-1];
            drv_oe  = !read_q;
         end
         default: begin
            drv_val = 1'b0;
            drv_oe  = 1'b0;
         end
      endcase
   end

   assign busy    = (field_q != FLD_IDLE);
   assign done    = done_q;
   assign is_read = read_q;
   assign field   = field_q;

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R9
   ignore_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_start) |=> $stable(read_q));

   // R9
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && field_q != FLD_PRE && cmd_start) |=> (field_q != FLD_PRE));

endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              sample_en,
   input  logic              mdi,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] shreg_q;

   generate
      if (DATA_W == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         shreg_q <= '0;
            else if (clear)     shreg_q <= '0;
            else if (sample_en) shreg_q <= mdi;
         end
      end else begin : g_wide
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         shreg_q <= '0;
            else if (clear)     shreg_q <= '0;
            else if (sample_en) shreg_q <= {shreg_q[DATA_W-2:0], mdi};
         end
      end
   endgenerate

   assign rd_data = shreg_q;

   // R7
   rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sample_en && !clear) |=> $stable(rd_data));

   // R7
   rx_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_en && !clear) |=> (rd_data[0] == $past(mdi)));

endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
   import mdio_mgmt_pkg::*;
#(
   parameter int HOLD_CYCLES   = 6,
   parameter int ADDR_W        = 5,
   parameter int DATA_W        = 16,
   parameter int PREAMBLE_BITS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_start,
   input  logic              cmd_read,
   input  logic [ADDR_W-1:0] cmd_phy,
   input  logic [ADDR_W-1:0] cmd_reg,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);

   generate
      if (HOLD_CYCLES < 1) begin : g_bad_hold
         $error("HOLD_CYCLES must be at least 1");
      end
   endgenerate

   logic        sample_stb;
   logic        bit_end;
   logic        launch;
   logic        is_read;
   logic        drv_val;
   logic        drv_oe;
   logic        sample_en;
   mdio_field_e field;

   mdio_phase_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (busy),
      .sample_stb (sample_stb),
      .bit_end    (bit_end),
      .mdc        (mdc)
   );

   mdio_frame_seq #(
      .ADDR_W        (ADDR_W),
      .DATA_W        (DATA_W),
      .PREAMBLE_BITS (PREAMBLE_BITS)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_start (cmd_start),
      .cmd_read  (cmd_read),
      .cmd_phy   (cmd_phy),
      .cmd_reg   (cmd_reg),
      .cmd_wdata (cmd_wdata),
      .bit_end   (bit_end),
      .launch    (launch),
      .busy      (busy),
      .done      (done),
      .is_read   (is_read),
      .field     (field),
      .drv_val   (drv_val),
      .drv_oe    (drv_oe)
   );

   assign sample_en = sample_stb && is_read && (field == FLD_DATA);

   mdio_rx_capture #(.DATA_W(DATA_W)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (launch),
      .sample_en (sample_en),
      .mdi       (mdio_i),
      .rd_data   (rd_data)
   );

   assign mdio_o  = drv_val;
   assign mdio_oe = drv_oe;

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdc && !mdio_oe));

   // R6
   bit_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !bit_end) |=> ($stable(mdio_o) && $stable(mdio_oe)));

   // R5
   rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sample_en |-> !mdio_oe);

endmodule

// File: tb/tb_mdio_frame_master.sv
module tb_mdio_frame_master;

   localparam int H = 6;
   localparam int P = 4 * H;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_start = 1'b0;
   logic        cmd_read = 1'b0;
   logic [4:0]  cmd_phy = '0;
   logic [4:0]  cmd_reg = '0;
   logic [15:0] cmd_wdata = '0;
   logic        busy, done, mdc, mdio_o, mdio_oe;
   logic [15:0] rd_data;
   logic        mdio_i = 1'b1;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   mdio_frame_master #(.HOLD_CYCLES(H)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_read(cmd_read),
      .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
      .busy(busy), .done(done), .rd_data(rd_data), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   // {read, phy, reg, wdata, mdi word}
   localparam logic [42:0] VEC [6] = '{
      {1'b0, 5'h00, 5'h00, 16'h8000, 16'h0000},
      {1'b1, 5'h1F, 5'h1F, 16'h0000, 16'hA5C3},
      {1'b0, 5'h15, 5'h0A, 16'hFFFF, 16'h0000},
      {1'b1, 5'h00, 5'h01, 16'h0000, 16'h0001},
      {1'b0, 5'h0A, 5'h15, 16'h1234, 16'h0000},
      {1'b1, 5'h03, 5'h1E, 16'hFFFF, 16'h8000}
   };

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // expected {oe, value} for bit b of a frame
   function automatic logic [1:0] exp_bit(input logic rd, input logic [4:0] ph,
                                          input logic [4:0] rg, input logic [15:0] wd, input int b);
      logic [13:0] cw;
      cw = {2'b01, (rd ? 2'b10 : 2'b01), ph, rg};
      if (b < 32) return 2'b11;
      if (b < 46) return {1'b1, cw[13-(b-32)]};
      if (rd) return 2'b00;
      if (b == 46) return 2'b11;
      if (b == 47) return 2'b10;
      if (b < 64) return {1'b1, wd[15-(b-48)]};
      return 2'b00;
   endfunction

   function automatic string req_of(input logic rd, input int b);
      if (b < 32) return "R2";
      if (b < 46) return "R3";
      return rd ? "R5" : "R4";
   endfunction

   task automatic run_frame(input logic rd, input logic [4:0] ph, input logic [4:0] rg,
                            input logic [15:0] wd, input logic [15:0] mdi_w, input bit inject);
      int nbits;
      nbits = rd ? 64 : 65;
      @(negedge clk);
      cmd_read = rd; cmd_phy = ph; cmd_reg = rg; cmd_wdata = wd; cmd_start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      cmd_start = 1'b0;
      for (int b = 0; b < nbits; b++) begin
         logic [1:0] e;
         bit bad_mdc, bad_busy, bad_drv;
         logic [1:0] seen;
         e = exp_bit(rd, ph, rg, wd, b);
         bad_mdc = 0; bad_busy = 0; bad_drv = 0; seen = {mdio_oe, mdio_o};
         for (int c = 0; c < P; c++) begin
            int p;
            p = c / H;
            if (rd && b >= 47 && b <= 62) begin
               if (c == 0) mdio_i = mdi_w[15-(b-47)];
               if (c == 2 * H) mdio_i = ~mdi_w[15-(b-47)];
            end else begin
               mdio_i = 1'b1;
            end
            if (inject && b == 50 && c == 0) begin
               cmd_start = 1'b1; cmd_read = ~rd; cmd_phy = ~ph; cmd_reg = ~rg;
            end
            if (inject && b == 50 && c == 1) cmd_start = 1'b0;
            if (mdc !== ((p == 1) || (p == 2))) bad_mdc = 1;
            if (busy !== 1'b1 || done !== 1'b0) bad_busy = 1;
            if (mdio_oe !== e[1]) bad_drv = 1;
            if (e[1] && mdio_o !== e[0]) bad_drv = 1;
            if ({mdio_oe, mdio_o} !== seen) bad_mdc = 1;
            @(negedge clk);
         end
         chk(!bad_mdc, "R6 mdc shape / steady drive", b, 0);
         chk(!bad_busy, "R8 busy during frame", b, 0);
         chk(!bad_drv, inject ? "R9 frame unchanged" : req_of(rd, b), b, {30'd0, e});
      end
      // now at cycle index nbits*P
      chk(done === 1'b1, "R8 done pulse", done, 1);
      chk(busy === 1'b0, "R8 busy low in done cycle", busy, 0);
      if (rd) chk(rd_data === mdi_w, "R7 read data", rd_data, mdi_w);
      @(negedge clk);
      chk(done === 1'b0, "R8 done one clock", done, 0);
      chk(mdc === 1'b0 && mdio_oe === 1'b0, "R1 idle lines", {mdc, mdio_oe}, 0);
      if (inject) chk(busy === 1'b0, "R9 no second frame", busy, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(busy === 0 && done === 0 && mdc === 0 && mdio_oe === 0, "R1 reset state",
          {busy, done, mdc, mdio_oe}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(busy === 0 && mdc === 0 && mdio_oe === 0, "R1 idle after reset", {busy, mdc, mdio_oe}, 0);

      for (int v = 0; v < 6; v++) begin
         logic [42:0] t;
         t = VEC[v];
         run_frame(t[42], t[41:37], t[36:32], t[31:16], t[15:0], 1'b0);
      end

      // R9 start while busy
      run_frame(1'b0, 5'h11, 5'h06, 16'hC0DE, 16'h0000, 1'b1);
      run_frame(1'b1, 5'h04, 5'h02, 16'h0000, 16'h5AA5, 1'b1);

      // R1 reset in mid-frame
      @(negedge clk);
      cmd_read = 1'b0; cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
      repeat (300) @(negedge clk);
      chk(busy === 1'b1, "R8 busy mid-frame", busy, 1);
      rst_n = 1'b0;
      @(negedge clk);
      chk(busy === 0 && done === 0 && mdc === 0 && mdio_oe === 0, "R1 reset mid-frame",
          {busy, done, mdc, mdio_oe}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(busy === 0 && mdc === 0, "R1 stays idle", {busy, mdc}, 0);

      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule